// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block models, cycle by cycle, the command interpreter of a byte-wide parallel flash memory. Each qualified write strobe carries an address and a data byte. The decoder tracks unlock sequences that span several cycles. When a program sequence completes, it issues a one-cycle program-start pulse. The pulse comes with the target address, the new data byte, and the merged byte that the array controller should store. The decoder also keeps a flag for identification mode. While that flag is set, the read path returns fixed code bytes in place of array contents.

The storage array, the erase algorithm and the program timing are outside the block. The array controller signals the end of a program with a one-cycle done input. While a program is in flight, the block ignores all write strobes. The unlock addresses, unlock data and command codes are all parameters.

Top module: `flash_cmd_seq`

## Requirements
- R1: During reset and just after it, prog_start is 0, busy is 0 and id_mode is 0.
- R2: The four writes UNLK_D1 at UNLK_A1, UNLK_D2 at UNLK_A2, CMD_PROG at UNLK_A1, then any byte at any address make prog_start 1 for exactly one cycle, in the cycle after the fourth write. prog_addr and prog_data equal the fourth write's address and data. If the third byte is anything other than CMD_PROG, the fourth write starts nothing.
- R3: prog_wdata equals prog_data AND prog_old, so a program can only clear bits.
- R4: The three writes UNLK_D1 at UNLK_A1, UNLK_D2 at UNLK_A2, CMD_ID at UNLK_A1 set id_mode in the cycle after the third write.
- R5: When id_mode is 1, rd_data is MFR_CODE (8'hDA) at rd_addr 0, DEV_CODE (8'h8C) at rd_addr 1, and 8'h00 at any other address. When id_mode is 0, rd_data equals arr_rdata. The read path is combinational.
- R6: The three-write sequence that ends with CMD_EXIT at UNLK_A1 clears id_mode.
- R7: A single write of CMD_EXIT at any address, made while no sequence is in progress, clears id_mode.
- R8: A write that does not match the expected address and data of the next cycle returns the decoder to idle. The partial sequence is discarded, and that write does not start a new sequence.
- R9: busy rises together with prog_start and falls in the cycle after prog_done. While busy is 1, write strobes are ignored, including a write made in the same cycle as prog_done.
- R10: The end of a program (prog_done while busy) clears id_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Qualified write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | AW | Read address |
| arr_rdata | input | 8 | Byte read from the array at rd_addr |
| prog_old | input | 8 | Current array byte at prog_addr |
| prog_done | input | 1 | Array controller reports that the program has finished |
| rd_data | output | 8 | Read data after the mode mux |
| id_mode | output | 1 | Identification mode flag |
| busy | output | 1 | A program is in flight |
| prog_start | output | 1 | One-cycle program start pulse |
| prog_addr | output | AW | Target address of the program |
| prog_data | output | 8 | New data byte of the program |
| prog_wdata | output | 8 | Merged byte to store (prog_data AND prog_old) |

## Verification
A write strobe and the end of a program can fall in the same cycle. The busy flag is still high on that edge, so the write must be dropped. The bench provokes this by asserting prog_done together with the first unlock write and then completing an identification entry sequence. The test passes only if id_mode stays 0, which shows the first write was lost. A second overlap is a program sequence that completes while identification mode is active. Here the bench checks that id_mode holds until prog_done and then clears.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_UNLK1 = 2'd1,
    SEQ_UNLK2 = 2'd2,
    SEQ_PADDR = 2'd3
  } seq_state_e;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] UNLK_A1 = 'h555,
  parameter logic [AW-1:0] UNLK_A2 = 'h2AA,
  parameter logic [7:0] UNLK_D1 = 8'hAA,
  parameter logic [7:0] UNLK_D2 = 8'h55,
  parameter logic [7:0] CMD_PROG = 8'hA0,
  parameter logic [7:0] CMD_ID = 8'h90,
  parameter logic [7:0] CMD_EXIT = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy,
  output logic          go_prog,
  output logic          id_set,
  output logic          id_clr
);
  seq_state_e state_q, state_d;
  logic wr_ok, hit_a1, hit_a2;

  assign wr_ok  = wr_en & ~busy;
  assign hit_a1 = (wr_addr == UNLK_A1);
  assign hit_a2 = (wr_addr == UNLK_A2);

  always_comb begin
    state_d = state_q;
    go_prog = 1'b0;
    id_set  = 1'b0;
    id_clr  = 1'b0;
    if (wr_ok) begin
      state_d = SEQ_IDLE;
      unique case (state_q)
        SEQ_IDLE: begin
          if (hit_a1 && wr_data == UNLK_D1) state_d = SEQ_UNLK1;
          else if (wr_data == CMD_EXIT)     id_clr  = 1'b1;
        end
        SEQ_UNLK1: begin
          if (hit_a2 && wr_data == UNLK_D2) state_d = SEQ_UNLK2;
        end
        SEQ_UNLK2: begin
          if (hit_a1) begin
            if (wr_data == CMD_PROG)      state_d = SEQ_PADDR;
            else if (wr_data == CMD_ID)   id_set  = 1'b1;
            else if (wr_data == CMD_EXIT) id_clr  = 1'b1;
          end
        end
        SEQ_PADDR: go_prog = 1'b1;
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/flash_prog_latch.sv
module flash_prog_latch #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_prog,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          prog_done,
  output logic          prog_start,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          busy
);
  logic busy_d, start_d;

  always_comb begin
    start_d = go_prog;
    busy_d  = busy;
    if (go_prog)        busy_d = 1'b1;
    else if (prog_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      prog_start <= start_d;
      busy       <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (go_prog) begin
      prog_addr <= wr_addr;
      prog_data <= wr_data;
    end
  end
endmodule

// File: rtl/flash_id_path.sv
module flash_id_path #(
  parameter int unsigned AW = 16,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'h8C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_set,
  input  logic          id_clr,
  input  logic          done_clr,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_rdata,
  output logic          id_mode,
  output logic [7:0]    rd_data
);
  localparam logic [AW-1:0] ID_MFR_ADDR = AW'(0);
  localparam logic [AW-1:0] ID_DEV_ADDR = AW'(1);

  logic id_d;

  always_comb begin
    id_d = id_mode;
    if (id_set)                 id_d = 1'b1;
    else if (id_clr | done_clr) id_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_mode <= 1'b0;
    else        id_mode <= id_d;
  end

  always_comb begin
    if (!id_mode)                   rd_data = arr_rdata;
    else if (rd_addr == ID_MFR_ADDR) rd_data = MFR_CODE;
    else if (rd_addr == ID_DEV_ADDR) rd_data = DEV_CODE;
    else                             rd_data = 8'h00;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] UNLK_A1 = 'h555,
  parameter logic [AW-1:0] UNLK_A2 = 'h2AA,
  parameter logic [7:0] UNLK_D1 = 8'hAA,
  parameter logic [7:0] UNLK_D2 = 8'h55,
  parameter logic [7:0] CMD_PROG = 8'hA0,
  parameter logic [7:0] CMD_ID = 8'h90,
  parameter logic [7:0] CMD_EXIT = 8'hF0,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'h8C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_rdata,
  input  logic [7:0]    prog_old,
  input  logic          prog_done,
  output logic [7:0]    rd_data,
  output logic          id_mode,
  output logic          busy,
  output logic          prog_start,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic [7:0]    prog_wdata
);
  logic go_prog, id_set, id_clr, done_clr;

  assign done_clr   = busy & prog_done;
  assign prog_wdata = prog_data & prog_old;

  flash_seq_fsm #(
    .AW(AW), .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2),
    .UNLK_D1(UNLK_D1), .UNLK_D2(UNLK_D2),
    .CMD_PROG(CMD_PROG), .CMD_ID(CMD_ID), .CMD_EXIT(CMD_EXIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .go_prog(go_prog),
    .id_set(id_set), .id_clr(id_clr)
  );

  flash_prog_latch #(.AW(AW)) u_prog (
    .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .prog_start(prog_start),
    .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy)
  );

  flash_id_path #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst_n(rst_n), .id_set(id_set), .id_clr(id_clr),
    .done_clr(done_clr), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .id_mode(id_mode), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int unsigned AW = 16,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'h8C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    arr_rdata,
  input logic [7:0]    prog_old,
  input logic          prog_done,
  input logic [7:0]    rd_data,
  input logic          id_mode,
  input logic          busy,
  input logic          prog_start,
  input logic [AW-1:0] prog_addr,
  input logic [7:0]    prog_data,
  input logic [7:0]    prog_wdata
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start); // R2
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy); // R9
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_start) |=> !prog_start); // R9
  AST_WDATA_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ((prog_wdata & ~prog_old) == 8'h00)); // R3
  AST_ID_MFR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == AW'(0)) |-> (rd_data == MFR_CODE)); // R5
  AST_ID_DEV_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == AW'(1)) |-> (rd_data == DEV_CODE)); // R5
  AST_ARRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (rd_data == arr_rdata)); // R5
  AST_DONE_ENDS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_start && prog_done) |=> (!busy && !id_mode)); // R10
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (.*);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int AW = 16;
  localparam logic [AW-1:0] A1 = 16'h0555;
  localparam logic [AW-1:0] A2 = 16'h02AA;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, prog_done;
  logic [AW-1:0] wr_addr, rd_addr, prog_addr;
  logic [7:0]    wr_data, arr_rdata, prog_old, rd_data, prog_data, prog_wdata;
  logic          id_mode, busy, prog_start;
  int            n_run = 0, n_fail = 0;
  bit            exp_id;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .prog_old(prog_old), .prog_done(prog_done), .rd_data(rd_data),
    .id_mode(id_mode), .busy(busy), .prog_start(prog_start),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_wdata(prog_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit with_done = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; prog_done = with_done;
    @(negedge clk);
    wr_en = 1'b0; prog_done = 1'b0;
  endtask

  task automatic unlock();
    wr(A1, 8'hAA);
    wr(A2, 8'h55);
  endtask

  task automatic done_pulse();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; prog_done = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; arr_rdata = 8'h5A; prog_old = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 prog_start", prog_start, 0);
    chk("R1 busy", busy, 0);
    chk("R1 id_mode", id_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 id_mode after release", id_mode, 0);

    // R5: normal mode reads pass array data
    for (int a = 0; a < 8; a++) begin
      rd_addr = AW'(a); arr_rdata = 8'(a * 17 + 3); #1;
      chk("R5 array read", rd_data, 8'(a * 17 + 3));
    end

    // R2/R4/R6: sweep every third-cycle command byte
    exp_id = 1'b0;
    prog_old = 8'hF0;
    for (int c = 0; c < 256; c++) begin
      unlock();
      wr(A1, 8'(c));
      if (c == 8'h90) exp_id = 1'b1;
      if (c == 8'hF0) exp_id = 1'b0;
      chk("R4 R6 id_mode after command", id_mode, exp_id);
      if (c == 8'hA0) begin
        wr(16'h1234, 8'h3C);
        chk("R2 start pulse", prog_start, 1);
        chk("R2 prog_addr", prog_addr, 16'h1234);
        chk("R2 prog_data", prog_data, 8'h3C);
        chk("R3 merged byte", prog_wdata, 8'h30);
        @(negedge clk);
        chk("R2 pulse ends", prog_start, 0);
        done_pulse();
        chk("R9 busy clears", busy, 0);
      end else begin
        wr(16'h0010, 8'h00);
        chk("R2 no start without program command", prog_start, 0);
      end
      if (exp_id) begin
        wr(16'h7777, 8'hF0);
        chk("R7 short exit", id_mode, 0);
        exp_id = 1'b0;
      end
    end

    // R5: identification reads, then long exit
    unlock(); wr(A1, 8'h90);
    arr_rdata = 8'hFF;
    for (int a = 0; a < 8; a++) begin
      rd_addr = AW'(a); #1;
      chk("R5 id read", rd_data, (a == 0) ? 8'hDA : (a == 1) ? 8'h8C : 8'h00);
    end
    unlock(); wr(A1, 8'hF0);
    chk("R6 long exit", id_mode, 0);
    rd_addr = '0; #1;
    chk("R5 array after exit", rd_data, 8'hFF);

    // R8: mismatches discard partial sequences
    wr(A1, 8'hAA); wr(A2, 8'h11); wr(A2, 8'h55); wr(A1, 8'hA0); wr(16'h0040, 8'h3C);
    chk("R8 wrong data no program", prog_start, 0);
    wr(A1, 8'hAA); wr(A2 + 16'h1, 8'h55); wr(A1, 8'h90);
    chk("R8 wrong address no id", id_mode, 0);
    unlock(); wr(A1 - 16'h1, 8'h90);
    chk("R8 wrong third address no id", id_mode, 0);

    // R3: AND merge sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] o, n;
      o = 8'(i * 8'h11) ^ 8'hA5;
      n = 8'(i * 8'h2B) ^ 8'h3C;
      unlock(); wr(A1, 8'hA0);
      prog_old = o;
      wr(AW'(i), n);
      chk("R3 merge sweep", prog_wdata, o & n);
      done_pulse();
    end

    // R9: writes ignored while busy, including in the done cycle
    unlock(); wr(A1, 8'hA0); wr(16'h0020, 8'h55);
    chk("R9 busy set", busy, 1);
    unlock(); wr(A1, 8'h90);
    chk("R9 id entry ignored while busy", id_mode, 0);
    unlock(); wr(A1, 8'hA0); wr(16'h0021, 8'h00);
    chk("R9 program ignored while busy", prog_start, 0);
    wr(A1, 8'hAA, 1'b1);
    chk("R9 busy falls after done", busy, 0);
    wr(A2, 8'h55); wr(A1, 8'h90);
    chk("R9 write in done cycle dropped", id_mode, 0);
    unlock(); wr(A1, 8'h90);
    chk("R9 id entry after busy", id_mode, 1);

    // R10: program end leaves identification mode
    unlock(); wr(A1, 8'hA0); wr(16'h0030, 8'h00);
    chk("R10 start from id mode", prog_start, 1);
    chk("R10 id held while busy", id_mode, 1);
    done_pulse();
    chk("R10 id cleared by completion", id_mode, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule